// File: doc/BRIEF.md
# NAND Bus Strobe Sequencer

This block produces the pin-level waveform for one NAND bus transaction at a time: a command byte latch, an address byte latch, a data write, a data read, or a wait for the array to become ready. A controller above it presents a request with a type code, a data value and a "last" flag. The block then walks chip-enable, the latch enables, the write and read strobes and the I/O drivers through a sequence of timed phases. When the sequence ends it raises a one-cycle completion pulse, and for a read that pulse carries the byte or word it captured.

Every phase length comes from a small field inside one of two packed timing words. A field holding c stretches its phase to c+1 clock cycles, so a zero field still gives a one-cycle phase. The block remembers what kind of cycle came last. With that it inserts the address-to-read or command-to-read turnaround before the first read that follows. Chip-enable stays low across a run of requests and is released, after its hold time, only at a request marked last. The bus can be used eight or sixteen bits wide.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is held and after it is released, ce_n, we_n and re_n are high, cle, ale, io_oe and done are low, and req_ready is high.
- R2: A request that finds chip-enable released drives ce_n low for tCS+1 cycles before any strobe phase starts, where tCS is timing word 0 bits 18:16. Strobes go low only while ce_n is low.
- R3: Type codes 0 (command), 1 (address) and 2 (data write) hold we_n low for tWP+1 cycles (word 0 bits 10:8) and then high for tWH+1 cycles (bits 13:11). io_oe is high and io_out carries the request data for the whole cycle. cle is high only for type 0 and ale only for type 1.
- R4: Type code 3 (data read) holds re_n low for tRP+1 cycles (word 0 bits 2:0) and then high for tRH+1 cycles (bits 5:3). io_in is captured on the last low cycle, and io_oe stays low.
- R5: The first read after an address cycle waits tAR+1 cycles (word 1 bits 3:0), and the first read after a command cycle waits tWHR+1 cycles (word 1 bits 7:4), before re_n falls. A read after a read has no extra wait.
- R6: For a request with req_last set, ce_n stays low for tCH+1 cycles (word 0 bits 21:19) after the strobe-high phase, then goes high before done. Without req_last, ce_n stays low after done.
- R7: Type code 4 (wait-busy) with rb_en high completes in the cycle after the first cycle in which rb_n is sampled high.
- R8: Type code 4 with rb_en low completes after tR+1 cycles (word 1 bits 31:16), and no strobe moves.
- R9: The largest field values give the longest phases: 7 in a 3-bit field gives 8 cycles and 15 in a 4-bit field gives 16 cycles.
- R10: done is a single-cycle pulse in the cycle after the final phase, req_ready is high in that cycle, and rd_data then holds the captured read value.
- R11: With bus_wide low, io_out bits above 7 are zero, and so are rd_data bits above 7.
- R12: Type codes 5 to 7 are dropped: no strobe, latch enable or chip-enable change and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tim_word0 | input | 32 | Packed CE hold/setup and write/read pulse and recovery fields |
| tim_word1 | input | 32 | Packed busy time, command-to-read and address-to-read fields |
| bus_wide | input | 1 | High for a 16-bit bus, low for an 8-bit bus |
| rb_en | input | 1 | High to finish wait-busy on rb_n, low to use the fixed busy time |
| req_valid | input | 1 | Request present |
| req_type | input | 3 | 0 command, 1 address, 2 data write, 3 data read, 4 wait-busy |
| req_data | input | DW | Command, address or write data value |
| req_last | input | 1 | Release chip-enable after this request |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| rb_n | input | 1 | Ready/busy line from the device (synchronous) |
| io_in | input | DW | I/O bus as read from the pads |
| ce_n | output | 1 | Chip-enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | DW | I/O bus value to drive |
| io_oe | output | 1 | I/O output enable |
| done | output | 1 | Request complete |
| rd_data | output | DW | Value captured by the last read |

## Verification
On every cycle the assertions check that cle and ale never overlap, that the two strobes never overlap, that a strobe low always falls inside chip-enable, that the I/O drivers are off while re_n is low, and that each we_n and re_n low pulse has exactly its programmed width. They also check that done is a lone pulse given only while idle. What only the bench scenarios can show is how phases are put together: the chip-enable setup and hold that wrap a run of requests, the choice of turnaround gap from the previous cycle's kind, the busy wait on rb_n against the fixed count, the sampling point of a read, and the narrow-bus masking. The bench checks these through end-to-end latency, strobe records and captured data.

// File: rtl/nstg_pkg.sv
// Shared types and helpers for the NAND strobe sequencer.
// Assumes request type codes are fixed at three bits.
package nstg_pkg;

    localparam int CNT_W = 16;

    localparam logic [2:0] REQ_CMD   = 3'd0;
    localparam logic [2:0] REQ_ADDR  = 3'd1;
    localparam logic [2:0] REQ_WDATA = 3'd2;
    localparam logic [2:0] REQ_RDATA = 3'd3;
    localparam logic [2:0] REQ_WAIT  = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_GAP, ST_LOW, ST_HIGH, ST_HOLD, ST_BUSY
    } phase_e;

    typedef enum logic [1:0] {
        PRIOR_NONE, PRIOR_CMD, PRIOR_ADDR
    } prior_e;

    typedef struct packed {
        logic [2:0]  ce_hold;
        logic [2:0]  ce_setup;
        logic [2:0]  wr_high;
        logic [2:0]  wr_pulse;
        logic [2:0]  rd_high;
        logic [2:0]  rd_pulse;
        logic [15:0] busy;
        logic [3:0]  cmd_to_rd;
        logic [3:0]  addr_to_rd;
    } tim_fields_t;

    function automatic logic is_write_kind(input logic [2:0] t);
        return (t == REQ_CMD) || (t == REQ_ADDR) || (t == REQ_WDATA);
    endfunction

    function automatic logic is_known_kind(input logic [2:0] t);
        return t <= REQ_WAIT;
    endfunction

endpackage

// File: rtl/nstg_timing_unpack.sv
// Splits the two packed timing words into named phase fields.
// Assumes the words are held stable while a request is in progress.
module nstg_timing_unpack
    import nstg_pkg::*;
(
    input  logic [31:0]  tim_word0,
    input  logic [31:0]  tim_word1,
    output tim_fields_t  fields
);

    logic unused_tim_bits;

    // Field extraction at the bit positions software programs.
    always_comb begin
        fields.ce_hold    = tim_word0[21:19];
        fields.ce_setup   = tim_word0[18:16];
        fields.wr_high    = tim_word0[13:11];
        fields.wr_pulse   = tim_word0[10:8];
        fields.rd_high    = tim_word0[5:3];
        fields.rd_pulse   = tim_word0[2:0];
        fields.busy       = tim_word1[31:16];
        fields.cmd_to_rd  = tim_word1[7:4];
        fields.addr_to_rd = tim_word1[3:0];
    end

    assign unused_tim_bits = ^{tim_word0[31:22], tim_word0[15:14],
                               tim_word0[7:6], tim_word1[15:8]};

endmodule

// File: rtl/nstg_phase_timer.sv
// Down-counter that sets the length of the current phase.
// Assumes a load of n is issued on entry to a phase; expired is then
// high in the phase's last cycle, giving n+1 cycles in all.
module nstg_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Count register: reload on phase entry, else step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/nstg_gap_tracker.sv
// Remembers the kind of the previous bus cycle and works out the
// turnaround a following read must wait before re_n falls.
// Assumes strobe_done pulses once per completed command/address/data
// cycle, and that a chip-enable release or busy wait clears history.
module nstg_gap_tracker
    import nstg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_done,
    input  logic [2:0]   done_kind,
    input  logic         clear,
    input  logic [3:0]   cmd_to_rd,
    input  logic [3:0]   addr_to_rd,
    output logic         gap_needed,
    output logic [W-1:0] gap_len
);

    prior_e prior;

    // History register of the last completed cycle kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prior <= PRIOR_NONE;
        end else if (clear) begin
            prior <= PRIOR_NONE;
        end else if (strobe_done) begin
            case (done_kind)
                REQ_CMD:  prior <= PRIOR_CMD;
                REQ_ADDR: prior <= PRIOR_ADDR;
                default:  prior <= PRIOR_NONE;
            endcase
        end
    end

    // Turnaround selection from the remembered kind.
    always_comb begin
        gap_needed = (prior != PRIOR_NONE);
        case (prior)
            PRIOR_ADDR: gap_len = W'(addr_to_rd);
            PRIOR_CMD:  gap_len = W'(cmd_to_rd);
            default:    gap_len = '0;
        endcase
    end

endmodule

// File: rtl/nstg_io_path.sv
// Data side of the bus: holds the value to drive, applies the bus
// width mask, and captures read data at the sampling strobe.
// Assumes bus_wide does not change while a request is in progress.
module nstg_io_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wide,
    input  logic          hold_wdata,
    input  logic [DW-1:0] wdata_in,
    input  logic          drive,
    input  logic          capture,
    input  logic [DW-1:0] io_in,
    output logic [DW-1:0] io_out,
    output logic          io_oe,
    output logic [DW-1:0] rd_data
);

    localparam int BYTE_W = 8;

    logic [DW-1:0] lane_mask;
    logic [DW-1:0] wdata_q;

    generate
        if (DW > BYTE_W) begin : g_wide
            assign lane_mask = {{(DW - BYTE_W){bus_wide}}, {BYTE_W{1'b1}}};
        end else begin : g_narrow
            logic unused_wide;
            assign unused_wide = bus_wide;
            assign lane_mask   = '1;
        end
    endgenerate

    // Write data holding register, loaded when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (hold_wdata) begin
            wdata_q <= wdata_in;
        end
    end

    // Read data register, loaded on the last read-low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture) begin
            rd_data <= io_in & lane_mask;
        end
    end

    assign io_oe  = drive;
    assign io_out = drive ? (wdata_q & lane_mask) : '0;

endmodule

// File: rtl/nand_strobe_gen.sv
// NAND bus strobe sequencer: runs one command, address, data or
// busy-wait request through its timed phases and pulses done.
// Assumes rb_n is already synchronous to clk and the timing words are
// static while busy. Chip-enable persists across requests until one
// marked last finishes.
module nand_strobe_gen
    import nstg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   tim_word0,
    input  logic [31:0]   tim_word1,
    input  logic          bus_wide,
    input  logic          rb_en,
    input  logic          req_valid,
    input  logic [2:0]    req_type,
    input  logic [DW-1:0] req_data,
    input  logic          req_last,
    output logic          req_ready,
    input  logic          rb_n,
    input  logic [DW-1:0] io_in,
    output logic          ce_n,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] io_out,
    output logic          io_oe,
    output logic          done,
    output logic [DW-1:0] rd_data
);

    tim_fields_t       tf;
    phase_e            st, st_nxt;
    logic [2:0]        cur_kind;
    logic [2:0]        sel_kind;
    logic              cur_last;
    logic              ce_on;
    logic              accept;
    logic              expired;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  low_len, high_len;
    logic              finish;
    logic              gap_needed;
    logic [CNT_W-1:0]  gap_len;
    logic              read_gap;
    logic              strobe_done;
    logic              hist_clear;
    logic              in_strobe;

    nstg_timing_unpack u_unpack (
        .tim_word0 (tim_word0),
        .tim_word1 (tim_word1),
        .fields    (tf)
    );

    nstg_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    nstg_gap_tracker #(.W(CNT_W)) u_gap (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_done (strobe_done),
        .done_kind   (cur_kind),
        .clear       (hist_clear),
        .cmd_to_rd   (tf.cmd_to_rd),
        .addr_to_rd  (tf.addr_to_rd),
        .gap_needed  (gap_needed),
        .gap_len     (gap_len)
    );

    nstg_io_path #(.DW(DW)) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wide   (bus_wide),
        .hold_wdata (accept),
        .wdata_in   (req_data),
        .drive      (in_strobe && is_write_kind(cur_kind)),
        .capture    ((st == ST_LOW) && (cur_kind == REQ_RDATA) && expired),
        .io_in      (io_in),
        .io_out     (io_out),
        .io_oe      (io_oe),
        .rd_data    (rd_data)
    );

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_ready && req_valid && is_known_kind(req_type);
    assign sel_kind  = (st == ST_IDLE) ? req_type : cur_kind;
    assign read_gap  = (sel_kind == REQ_RDATA) && gap_needed;
    assign in_strobe = (st == ST_LOW) || (st == ST_HIGH);

    // Strobe-low and strobe-high lengths for the selected request kind.
    always_comb begin
        if (is_write_kind(sel_kind)) begin
            low_len  = CNT_W'(tf.wr_pulse);
            high_len = CNT_W'(tf.wr_high);
        end else begin
            low_len  = CNT_W'(tf.rd_pulse);
            high_len = CNT_W'(tf.rd_high);
        end
    end

    // Phase sequencing: next phase, its length and the completion point.
    always_comb begin
        st_nxt   = st;
        load     = 1'b0;
        load_val = '0;
        finish   = 1'b0;
        case (st)
            ST_IDLE: begin
                if (accept) begin
                    load = 1'b1;
                    if (req_type == REQ_WAIT) begin
                        st_nxt   = ST_BUSY;
                        load_val = tf.busy;
                    end else if (!ce_on) begin
                        st_nxt   = ST_SETUP;
                        load_val = CNT_W'(tf.ce_setup);
                    end else if (read_gap) begin
                        st_nxt   = ST_GAP;
                        load_val = gap_len;
                    end else begin
                        st_nxt   = ST_LOW;
                        load_val = low_len;
                    end
                end
            end
            ST_SETUP: begin
                if (expired) begin
                    load = 1'b1;
                    if (read_gap) begin
                        st_nxt   = ST_GAP;
                        load_val = gap_len;
                    end else begin
                        st_nxt   = ST_LOW;
                        load_val = low_len;
                    end
                end
            end
            ST_GAP: begin
                if (expired) begin
                    load     = 1'b1;
                    st_nxt   = ST_LOW;
                    load_val = low_len;
                end
            end
            ST_LOW: begin
                if (expired) begin
                    load     = 1'b1;
                    st_nxt   = ST_HIGH;
                    load_val = high_len;
                end
            end
            ST_HIGH: begin
                if (expired) begin
                    if (cur_last) begin
                        load     = 1'b1;
                        st_nxt   = ST_HOLD;
                        load_val = CNT_W'(tf.ce_hold);
                    end else begin
                        st_nxt = ST_IDLE;
                        finish = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (expired) begin
                    st_nxt = ST_IDLE;
                    finish = 1'b1;
                end
            end
            ST_BUSY: begin
                if (rb_en ? rb_n : expired) begin
                    st_nxt = ST_IDLE;
                    finish = 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign strobe_done = (st == ST_HIGH) && expired;
    assign hist_clear  = ((st == ST_HOLD) && expired) || ((st == ST_BUSY) && finish);

    // Phase state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Request capture: kind and last flag held for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind <= REQ_CMD;
            cur_last <= 1'b0;
        end else if (accept) begin
            cur_kind <= req_type;
            cur_last <= req_last;
        end
    end

    // Chip-enable state: taken at setup entry, dropped when hold ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_on <= 1'b0;
        end else if ((st == ST_IDLE) && (st_nxt == ST_SETUP)) begin
            ce_on <= 1'b1;
        end else if ((st == ST_HOLD) && expired) begin
            ce_on <= 1'b0;
        end
    end

    // Completion pulse, registered one cycle after the final phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= finish;
        end
    end

    // Pin decode from the current phase.
    always_comb begin
        ce_n = !ce_on;
        we_n = !((st == ST_LOW) && is_write_kind(cur_kind));
        re_n = !((st == ST_LOW) && (cur_kind == REQ_RDATA));
        cle  = in_strobe && (cur_kind == REQ_CMD);
        ale  = in_strobe && (cur_kind == REQ_ADDR);
    end

endmodule

// File: rtl/nstg_checker.sv
// Cycle-level protocol checks for the NAND strobe sequencer, bound
// to every instance of the top module.
module nstg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] tim_word0,
    input logic        req_ready,
    input logic        ce_n,
    input logic        cle,
    input logic        ale,
    input logic        we_n,
    input logic        re_n,
    input logic        io_oe,
    input logic        done
);

    logic       we_low_prev, re_low_prev;
    logic [3:0] we_low_len, re_low_len;

    // Length of the most recent we_n and re_n low runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_prev <= 1'b0;
            re_low_prev <= 1'b0;
            we_low_len  <= '0;
            re_low_len  <= '0;
        end else begin
            we_low_prev <= !we_n;
            re_low_prev <= !re_n;
            if (!we_n) we_low_len <= we_low_prev ? we_low_len + 1'b1 : 4'd1;
            if (!re_n) re_low_len <= re_low_prev ? re_low_len + 1'b1 : 4'd1;
        end
    end

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R4
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n); // R2
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe); // R4
    AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && we_low_prev) |-> (we_low_len == {1'b0, tim_word0[10:8]} + 4'd1)); // R3
    AST_RE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (re_n && re_low_prev) |-> (re_low_len == {1'b0, tim_word0[2:0]} + 4'd1)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R10

endmodule

bind nand_strobe_gen nstg_checker u_nstg_checker (.*);

// File: tb/nand_strobe_gen_bench.sv
`timescale 1ns/1ps
module nand_strobe_gen_bench;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   tim_word0 = '0;
    logic [31:0]   tim_word1 = '0;
    logic          bus_wide = 1'b1;
    logic          rb_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_type = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_last = 1'b0;
    logic          req_ready;
    logic          rb_n = 1'b1;
    logic [DW-1:0] io_in = '0;
    logic          ce_n, cle, ale, we_n, re_n, io_oe, done;
    logic [DW-1:0] io_out, rd_data;

    int checks = 0;
    int errors = 0;

    // Bench copy of the programmed fields and of the bus history.
    int t_ch, t_cs, t_wh, t_wp, t_rh, t_rp, t_r, t_whr, t_ar;
    bit m_ce_on = 0;
    int m_prior = 0;  // 0 none, 1 command, 2 address
    logic [15:0] rd_pat = '0;

    // Scoreboard queues: completions and strobe pulses.
    logic [32:0] exp_done[$];   // {check data, latency, data}
    string       done_tag[$];
    logic [26:0] exp_strobe[$]; // {is read, low cycles, cle, ale, data}
    string       strobe_tag[$];

    int  lat = 0;
    int  done_seen = 0;
    int  activity = 0;
    bit  prev_done = 0;

    always #4 clk = ~clk;

    nand_strobe_gen #(.DW(DW)) u_nand_strobe_gen (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_timing(input int ch, cs, wh, wp, rh, rp, tr, whr, ar);
        t_ch = ch; t_cs = cs; t_wh = wh; t_wp = wp; t_rh = rh; t_rp = rp;
        t_r = tr; t_whr = whr; t_ar = ar;
        tim_word0 = (32'(ch) << 19) | (32'(cs) << 16) | (32'(wh) << 11) |
                    (32'(wp) << 8) | (32'(rh) << 3) | 32'(rp);
        tim_word1 = (32'(tr) << 16) | (32'(whr) << 4) | 32'(ar);
    endtask

    // Driver: computes the expected outcome and pushes it, then drives.
    task automatic issue(input logic [2:0] t, input logic [15:0] d, input bit last,
                         input logic [15:0] pat, input int rb_delay, input string tag);
        int n;
        logic [15:0] mask;
        logic [15:0] expd;
        bit rd;
        mask = bus_wide ? 16'hFFFF : 16'h00FF;
        rd = (t == 3'd3);
        if (t == 3'd4) begin
            n = rb_en ? rb_delay + 1 : t_r + 1;
            m_prior = 0;
            exp_done.push_back({1'b0, 16'(n + 1), 16'h0});
        end else begin
            n = m_ce_on ? 0 : t_cs + 1;
            if (rd) n += (m_prior == 2) ? t_ar + 1 : (m_prior == 1) ? t_whr + 1 : 0;
            n += rd ? (t_rp + 1 + t_rh + 1) : (t_wp + 1 + t_wh + 1);
            if (last) n += t_ch + 1;
            expd = (pat + 16'(t_rp + 1)) & mask;
            exp_done.push_back({rd, 16'(n + 1), rd ? expd : 16'h0});
            if (rd) exp_strobe.push_back({1'b1, 8'(t_rp + 1), 1'b0, 1'b0, 16'h0});
            else exp_strobe.push_back({1'b0, 8'(t_wp + 1), t == 3'd0, t == 3'd1, d & mask});
            strobe_tag.push_back(tag);
            m_ce_on = !last;
            m_prior = last ? 0 : rd ? 0 : (t == 3'd0) ? 1 : (t == 3'd1) ? 2 : 0;
        end
        done_tag.push_back(tag);
        rd_pat = pat;
        @(posedge clk); #1;
        req_valid = 1'b1; req_type = t; req_data = d; req_last = last;
        if (t == 3'd4) rb_n = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (t == 3'd4 && rb_en) begin
            repeat (rb_delay) @(posedge clk);
            #1 rb_n = 1'b1;
        end
        do @(negedge clk); while (exp_done.size() != 0);
        if (t != 3'd4)
            check(ce_n == last, "R6", "ce_n after done", ce_n, last);
        rb_n = 1'b1;
    endtask

    // Flash model: read data changes on every read-low cycle.
    int f_run = 0;
    always @(negedge clk) begin
        if (!re_n) begin
            f_run++;
            io_in <= rd_pat + 16'(f_run);
        end else begin
            f_run = 0;
            io_in <= 16'h0;
        end
    end

    // Monitor: measures strobe pulses and completions against the queues.
    int we_run = 0, re_run = 0;
    bit oe_ok = 1;
    logic we_cle, we_ale;
    logic [15:0] we_dat;
    always @(negedge clk) begin
        logic [32:0] e;
        logic [26:0] s;
        string tg;
        if (rst_n) begin
            lat++;
            if (!we_n || !re_n || cle || ale) activity++;
            if (!we_n) begin
                we_run++; we_cle = cle; we_ale = ale; we_dat = io_out;
                if (!io_oe) oe_ok = 0;
            end else if (we_run > 0) begin
                if (exp_strobe.size() == 0) check(0, "R3", "unexpected write strobe", 0, 1);
                else begin
                    s = exp_strobe.pop_front(); tg = strobe_tag.pop_front();
                    check(s == {1'b0, 8'(we_run), we_cle, we_ale, we_dat}, tg,
                          "write pulse {rd,len,cle,ale,data}", {1'b0, 8'(we_run), we_cle, we_ale, we_dat}, s);
                    check(oe_ok, "R3", "io_oe across write low", oe_ok, 1);
                end
                we_run = 0; oe_ok = 1;
            end
            if (!re_n) begin
                re_run++;
                if (io_oe) oe_ok = 0;
            end else if (re_run > 0) begin
                if (exp_strobe.size() == 0) check(0, "R4", "unexpected read strobe", 0, 1);
                else begin
                    s = exp_strobe.pop_front(); tg = strobe_tag.pop_front();
                    check(s == {1'b1, 8'(re_run), 1'b0, 1'b0, 16'h0}, tg,
                          "read pulse {rd,len}", {1'b1, 8'(re_run), 18'h0}, s);
                    check(oe_ok, "R4", "io_oe low across read", oe_ok, 1);
                end
                re_run = 0; oe_ok = 1;
            end
            if (done) begin
                done_seen++;
                check(!prev_done && req_ready, "R10", "done single and idle", {prev_done, req_ready}, 2'b01);
                if (exp_done.size() == 0) check(0, "R12", "unexpected done", 1, 0);
                else begin
                    e = exp_done.pop_front(); tg = done_tag.pop_front();
                    check(lat == int'(e[31:16]), tg, "latency", lat, e[31:16]);
                    if (e[32]) check(rd_data == e[15:0], tg, "read data", rd_data, e[15:0]);
                end
            end
            prev_done = done;
            if (req_valid && req_ready && req_type <= 3'd4) lat = 0;
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int act0, dn0;
        logic ce0;
        set_timing(2, 3, 1, 2, 1, 3, 20, 5, 4);
        repeat (4) @(negedge clk);
        check({ce_n, we_n, re_n, cle, ale, io_oe, done, req_ready} == 8'b1110_0001,
              "R1", "pins in reset", {ce_n, we_n, re_n, cle, ale, io_oe, done, req_ready}, 8'b1110_0001);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check({ce_n, we_n, re_n, cle, ale, io_oe, done, req_ready} == 8'b1110_0001,
              "R1", "pins after reset", {ce_n, we_n, re_n, cle, ale, io_oe, done, req_ready}, 8'b1110_0001);

        // Page read: setup, command, addresses, confirm, busy on rb_n.
        issue(3'd0, 16'h0000, 0, 0, 0, "R2");
        issue(3'd1, 16'h0012, 0, 0, 0, "R3");
        issue(3'd1, 16'h0034, 0, 0, 0, "R3");
        issue(3'd0, 16'h0030, 0, 0, 0, "R3");
        rb_en = 1'b1;
        issue(3'd4, 16'h0, 0, 0, 5, "R7");
        issue(3'd3, 16'h0, 0, 16'h1100, 0, "R4");
        issue(3'd3, 16'h0, 1, 16'h2200, 0, "R6");

        // Identify: read after address takes tAR, then back-to-back reads.
        issue(3'd0, 16'h0090, 0, 0, 0, "R2");
        issue(3'd1, 16'h0000, 0, 0, 0, "R3");
        issue(3'd3, 16'h0, 0, 16'hA500, 0, "R5");
        issue(3'd3, 16'h0, 0, 16'hA600, 0, "R5");
        // Status: read after command takes tWHR.
        issue(3'd0, 16'h0070, 0, 0, 0, "R3");
        issue(3'd3, 16'h0, 1, 16'h0040, 0, "R5");

        // Program: data writes, confirm, fixed busy time.
        issue(3'd0, 16'h0080, 0, 0, 0, "R2");
        issue(3'd2, 16'hBEEF, 0, 0, 0, "R3");
        issue(3'd2, 16'h1234, 0, 0, 0, "R3");
        issue(3'd0, 16'h0010, 1, 0, 0, "R6");
        rb_en = 1'b0;
        act0 = activity;
        issue(3'd4, 16'h0, 0, 0, 0, "R8");
        check(activity == act0, "R8", "strobe activity during busy", activity, act0);

        // Largest field values.
        set_timing(7, 7, 7, 7, 7, 7, 40, 15, 15);
        issue(3'd0, 16'h0070, 0, 0, 0, "R9");
        issue(3'd3, 16'h0, 1, 16'h0300, 0, "R9");
        issue(3'd0, 16'h0090, 0, 0, 0, "R9");
        issue(3'd1, 16'h0000, 0, 0, 0, "R9");
        issue(3'd3, 16'h0, 1, 16'h0700, 0, "R9");

        // Narrow bus.
        set_timing(1, 0, 0, 0, 0, 0, 10, 2, 3);
        bus_wide = 1'b0;
        issue(3'd0, 16'h12EC, 0, 0, 0, "R11");
        issue(3'd3, 16'h0, 1, 16'h55F0, 0, "R11");
        bus_wide = 1'b1;

        // Reserved type codes are dropped.
        for (int c = 5; c <= 7; c++) begin
            act0 = activity; dn0 = done_seen; ce0 = ce_n;
            @(posedge clk); #1;
            req_valid = 1'b1; req_type = 3'(c); req_data = 16'h00FF; req_last = 1'b0;
            @(posedge clk); #1 req_valid = 1'b0;
            repeat (10) @(negedge clk);
            check(activity == act0 && done_seen == dn0 && ce_n == ce0, "R12",
                  "reserved code effect", {activity - act0, done_seen - dn0, ce_n}, {ce0});
        end

        check(exp_strobe.size() == 0 && exp_done.size() == 0, "R10", "leftover expectations",
              exp_strobe.size() + exp_done.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule